// File: doc/BRIEF.md
# Four-Way Tree Pseudo-LRU Victim Selector

This block holds the replacement state for every set of a four-way set-associative cache. Each set keeps three bits that form a binary tree. The root bit records which pair of ways was touched most recently. Each of the two leaf bits records which member of its pair was touched most recently. Whenever the cache reports a hit or a fill, it names the set and the way with the access strobe, and only the bits on that way's path in that set change.

The cache controller also presents a set index on a separate query port. The block answers combinationally with the way to evict. The answer walks the tree away from the recently used side at each level. The result approximates least-recently-used order and is not exact. When an update and a query target the same set in the same cycle, the answer is based on the state before the update. Tag storage and data arrays live outside this block.

Top module: `plru_sel`

## Requirements
- R1: After reset every set's three state bits are 0, and the victim for any queried set is way 1.
- R2: After an access to way 0 or way 1 of a set, the root bit of that set is 1 and that set's victim is way 2 or way 3.
- R3: After an access to way 2 or way 3 of a set, the root bit of that set is 0 and that set's victim is way 0 or way 1.
- R4: When the root bit is 0, the victim is taken from the lower pair. It is way 0 if way 1 was the last lower-pair way accessed (leaf bit 1 = 1). It is way 1 if way 0 was the last (leaf bit 1 = 0).
- R5: When the root bit is 1, the victim is taken from the upper pair. It is way 3 if way 2 was the last upper-pair way accessed (leaf bit 2 = 1). It is way 2 if way 3 was the last (leaf bit 2 = 0).
- R6: An access changes only the root bit and its own pair's leaf bit. The other pair's leaf bit keeps its value, so the victim can differ from the true least-recently-used way.
- R7: An access to one set leaves the victim of every other set unchanged.
- R8: A query and an access to the same set in one cycle return the victim from the pre-update state. The updated victim appears from the next cycle on.
- R9: With the access strobe low, the way and set inputs have no effect on any state.
- R10: Immediately after an access, the victim of that set is never the way just accessed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Strobe: a hit or fill occurred this cycle |
| acc_set_i | input | IDX_W | Set index of the access |
| acc_way_i | input | 2 | Way accessed (0..3) |
| qry_set_i | input | IDX_W | Set index whose victim is requested |
| victim_o | output | 2 | Way to replace for qry_set_i (combinational) |

## Verification
The assertions assume that the way and set inputs are free of X whenever the strobe is high. The pair and never-the-MRU properties are written for the case where the query in the following cycle names the set just accessed, so the stimulus always queries a set one cycle after it accesses that set. The stability property assumes the query set holds steady between two compared cycles, so every scenario keeps the query index fixed across each access it checks. The bench drives all inputs on the falling edge with defined values, so the known-output check always sees resolved operands.

// File: rtl/plru_pkg.sv
package plru_pkg;
  localparam int WAY_W = 2;
  typedef logic [WAY_W-1:0] way_t;
  // root: 1 = lower pair (ways 0/1) touched last
  // lo_w1: 1 = way 1 last in lower pair; up_w2: 1 = way 2 last in upper pair
  typedef struct packed {
    logic up_w2;
    logic lo_w1;
    logic root;
  } tree_t;
endpackage

// File: rtl/plru_update.sv
module plru_update
  import plru_pkg::*;
(
  input  tree_t cur_i,
  input  way_t  way_i,
  output tree_t nxt_o
);
  always_comb begin
    nxt_o = cur_i;
    if (!way_i[1]) begin
      nxt_o.root  = 1'b1;
      nxt_o.lo_w1 = way_i[0];
    end else begin
      nxt_o.root  = 1'b0;
      nxt_o.up_w2 = ~way_i[0];
    end
  end
endmodule

// File: rtl/plru_victim.sv
module plru_victim
  import plru_pkg::*;
(
  input  tree_t tree_i,
  output way_t  victim_o
);
  always_comb begin
    if (tree_i.root) victim_o = tree_i.up_w2 ? way_t'(3) : way_t'(2);
    else             victim_o = tree_i.lo_w1 ? way_t'(0) : way_t'(1);
  end
endmodule

// File: rtl/plru_sel.sv
module plru_sel
  import plru_pkg::*;
#(
  parameter int SETS  = 256,
  parameter int IDX_W = $clog2(SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_valid_i,
  input  logic [IDX_W-1:0] acc_set_i,
  input  logic [1:0]       acc_way_i,
  input  logic [IDX_W-1:0] qry_set_i,
  output logic [1:0]       victim_o
);
  tree_t st [SETS];
  tree_t upd_cur;
  tree_t upd_nxt;

  assign upd_cur = st[acc_set_i];

  plru_update u_upd (
    .cur_i (upd_cur),
    .way_i (acc_way_i),
    .nxt_o (upd_nxt)
  );

  for (genvar s = 0; s < SETS; s++) begin : g_set
    tree_t q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        q <= '0;
      else if (acc_valid_i && acc_set_i == IDX_W'(s))
        q <= upd_nxt;
    end
    assign st[s] = q;
  end

  // query reads registered state: same-cycle update is not yet visible
  plru_victim u_vic (
    .tree_i   (st[qry_set_i]),
    .victim_o (victim_o)
  );
endmodule

// File: rtl/plru_sel_chk.sv
module plru_sel_chk #(
  parameter int IDX_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             acc_valid_i,
  input logic [IDX_W-1:0] acc_set_i,
  input logic [1:0]       acc_way_i,
  input logic [IDX_W-1:0] qry_set_i,
  input logic [1:0]       victim_o
);
  AST_VICTIM_KNOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown(victim_o)); // R1

  AST_OTHER_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i |=> (qry_set_i != $past(acc_set_i)) || (victim_o[1] != $past(acc_way_i[1]))); // R2

  AST_NOT_MRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i |=> (qry_set_i != $past(acc_set_i)) || (victim_o != $past(acc_way_i))); // R10

  AST_UNTOUCHED_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_valid_i || acc_set_i != qry_set_i) |=> !$stable(qry_set_i) || $stable(victim_o)); // R7
endmodule

bind plru_sel plru_sel_chk #(.IDX_W(IDX_W)) u_chk (.*);

// File: tb/plru_sel_tb.sv
module plru_sel_tb;
  localparam int IDX_W = 8;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             acc_valid_i = 1'b0;
  logic [IDX_W-1:0] acc_set_i = '0;
  logic [1:0]       acc_way_i = '0;
  logic [IDX_W-1:0] qry_set_i = '0;
  logic [1:0]       victim_o;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  plru_sel #(.SETS(256)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .acc_valid_i(acc_valid_i),
    .acc_set_i(acc_set_i), .acc_way_i(acc_way_i),
    .qry_set_i(qry_set_i), .victim_o(victim_o)
  );

  task automatic peek(input int set, input int exp, input string req);
    qry_set_i = IDX_W'(set);
    #1;
    n_chk++;
    if (victim_o !== 2'(exp)) begin
      n_fail++;
      $display("FAIL %s set %0d: victim %0d expected %0d", req, set, victim_o, exp);
    end
  endtask

  task automatic access(input int set, input int way);
    @(negedge clk);
    acc_valid_i = 1'b1;
    acc_set_i   = IDX_W'(set);
    acc_way_i   = 2'(way);
    @(negedge clk);
    acc_valid_i = 1'b0;
  endtask

  task automatic t_reset;
    peek(0, 1, "R1"); peek(5, 1, "R1"); peek(255, 1, "R1");
  endtask

  task automatic t_root;
    access(3, 0); peek(3, 2, "R2");
    access(4, 1); peek(4, 2, "R2");
    access(6, 2); peek(6, 1, "R3");
    access(7, 3); peek(7, 1, "R3");
  endtask

  task automatic t_leaves;
    access(8, 2);  access(8, 0);  peek(8, 3, "R5");
    access(9, 3);  access(9, 1);  peek(9, 2, "R5");
    access(10, 1); access(10, 3); peek(10, 0, "R4");
    access(11, 0); access(11, 2); peek(11, 1, "R4");
  endtask

  task automatic t_path_only;
    // order 0,2,3,1: upper leaf left at way 3 -> victim 2, though way 0 is true LRU
    access(12, 0); access(12, 2); access(12, 3); access(12, 1);
    peek(12, 2, "R6");
    access(13, 1); access(13, 2); access(13, 0);
    peek(13, 3, "R6");
  endtask

  task automatic t_sets;
    access(20, 0);
    peek(21, 1, "R7"); peek(19, 1, "R7"); peek(20, 2, "R7");
  endtask

  task automatic t_no_strobe;
    @(negedge clk);
    acc_valid_i = 1'b0; acc_set_i = 8'd22; acc_way_i = 2'd0;
    @(negedge clk);
    peek(22, 1, "R9");
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    qry_set_i = 8'd30;
    acc_valid_i = 1'b1; acc_set_i = 8'd30; acc_way_i = 2'd0;
    peek(30, 1, "R8");
    @(negedge clk);
    acc_valid_i = 1'b0;
    peek(30, 2, "R8");
  endtask

  task automatic t_not_mru;
    for (int w = 0; w < 4; w++) begin
      access(40, w);
      qry_set_i = 8'd40;
      #1;
      n_chk++;
      if (victim_o === 2'(w)) begin
        n_fail++;
        $display("FAIL R10 set 40: victim %0d expected not %0d", victim_o, w);
      end
    end
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_root();
    t_leaves();
    t_path_only();
    t_sets();
    t_no_strobe();
    t_same_cycle();
    t_not_mru();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    #2000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end
endmodule